// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. Its remainder register is `FCS_W` bits wide. Feedback taps come from a divisor polynomial of `FCS_W+1` bits, with the highest term dropped. The remainder width and the divisor are parameters.

A frame begins with a `start` pulse. That pulse clears the register and latches the operating mode.

- **Generate mode:** the sender shifts the message in. After the bit flagged as the end of the message, the block shifts the remainder out, most significant bit first, for `FCS_W` cycles. That remainder is appended to the message as the frame check sequence.
- **Check mode:** the receiver shifts in the whole received frame, message bits then check bits. One cycle after the final bit, a flag reports whether the register ended at zero. The result then stays put until the next `start`.

Top module: `serial_fcs_unit`

## Requirements
- R1: While reset is asserted and after it is released, `fcs_out_valid`, `chk_done` and `chk_ok` are 0 until a frame produces a result.
- R2: In generate mode (`mode_check`=0 at `start`), `fcs_out_valid` is 1 for exactly `FCS_W` cycles, starting one cycle after the input bit that carries `msg_end`. `fcs_out` then presents the remainder of message·X^FCS_W modulo the divisor, most significant bit first. With the default divisor 110101, message 1010001101 gives 0,1,1,1,0.
- R3: In check mode (`mode_check`=1 at `start`), a frame made of a message followed by its correct check bits gives `chk_done`=1 and `chk_ok`=1. Both appear one cycle after the bit that carries `msg_end`.
- R4: In check mode, a frame with any single bit inverted gives `chk_done`=1 with `chk_ok`=0.
- R5: `chk_done` and `chk_ok` hold their values until the next `start`, and that `start` clears both.
- R6: Cycles with `bit_valid`=0 do not advance the computation, so gaps between bits leave the result unchanged.
- R7: A `start` during a frame discards all prior bits. The next frame's result depends only on the bits after that `start`.
- R8: Input bits are ignored when no frame is open: before any `start`, after a check result, and while check bits are being shifted out.
- R9: An all-zero message yields an all-zero check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the register and opens a frame; has priority over all other inputs |
| mode_check | input | 1 | Sampled at `start`: 0 = generate, 1 = check |
| bit_in | input | 1 | Serial data bit, most significant first |
| bit_valid | input | 1 | `bit_in` is taken this cycle |
| msg_end | input | 1 | With `bit_valid`, marks the last bit (the message in generate mode, the frame in check mode) |
| fcs_out | output | 1 | Serial check bit, most significant first |
| fcs_out_valid | output | 1 | `fcs_out` carries a check bit |
| chk_done | output | 1 | A check result is available |
| chk_ok | output | 1 | The checked frame left the register at zero |

## Verification
A corrupted remainder cannot be seen while bits are going in. It appears at the ports only when the frame closes. In generate mode it shows as a wrong serial bit during the `FCS_W` cycles that follow `msg_end`. In check mode it shows as a wrong `chk_ok` on the cycle after the last bit. A wrong tap or shift direction is therefore caught at the first frame end. A fault in the phase or counter logic shows as an emission burst of the wrong length, or as results that change without a `start`.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ABSORB = 2'd1,
        PH_EMIT   = 2'd2
    } phase_e;

endpackage

// File: rtl/fcs_tap_step.sv
// One serial division step: shift left, fold the feedback bit into the tapped positions.
module fcs_tap_step #(
    parameter int         W       = 5,
    parameter logic [W:0] DIVISOR = 6'b110101
) (
    input  logic [W-1:0] rem_in,
    input  logic         bit_in,
    output logic [W-1:0] rem_out
);
    logic fb;
    assign fb = rem_in[W-1] ^ bit_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            if (DIVISOR[0]) begin : g_tap
                assign rem_out[0] = fb;
            end else begin : g_plain
                assign rem_out[0] = 1'b0;
            end
        end else begin : g_hi
            if (DIVISOR[i]) begin : g_tap
                assign rem_out[i] = rem_in[i-1] ^ fb;
            end else begin : g_plain
                assign rem_out[i] = rem_in[i-1];
            end
        end
    end
endmodule

// File: rtl/fcs_zero_detect.sv
module fcs_zero_detect #(
    parameter int W = 5
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    assign is_zero = ~|value;
endmodule

// File: rtl/serial_fcs_unit.sv
module serial_fcs_unit #(
    parameter int             FCS_W   = 5,
    parameter logic [FCS_W:0] DIVISOR = 6'b110101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_check,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic msg_end,
    output logic fcs_out,
    output logic fcs_out_valid,
    output logic chk_done,
    output logic chk_ok
);
    import fcs_pkg::*;

    localparam int CNT_W = $clog2(FCS_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FCS_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic               chk_mode;
        logic [FCS_W-1:0]   rem;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               ok;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [FCS_W-1:0] step_rem;
    logic             step_zero;

    fcs_tap_step #(.W(FCS_W), .DIVISOR(DIVISOR)) u_step (
        .rem_in  (ctl_q.rem),
        .bit_in  (bit_in),
        .rem_out (step_rem)
    );

    fcs_zero_detect #(.W(FCS_W)) u_zero (
        .value   (step_rem),
        .is_zero (step_zero)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_ABSORB: begin
                if (bit_valid) begin
                    ctl_d.rem = step_rem;
                    if (msg_end) begin
                        if (ctl_q.chk_mode) begin
                            ctl_d.done  = 1'b1;
                            ctl_d.ok    = step_zero;
                            ctl_d.phase = PH_IDLE;
                        end else begin
                            ctl_d.cnt   = '0;
                            ctl_d.phase = PH_EMIT;
                        end
                    end
                end
            end
            PH_EMIT: begin
                // feedback off: plain shift toward the serial output
                ctl_d.rem = {ctl_q.rem[FCS_W-2:0], 1'b0};
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_IDX) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ;
        endcase

        if (start) begin
            ctl_d.phase    = PH_ABSORB;
            ctl_d.chk_mode = mode_check;
            ctl_d.rem      = '0;
            ctl_d.cnt      = '0;
            ctl_d.done     = 1'b0;
            ctl_d.ok       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, chk_mode: 1'b0, rem: '0, cnt: '0, done: 1'b0, ok: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fcs_out_valid = (ctl_q.phase == PH_EMIT);
    assign fcs_out       = fcs_out_valid & ctl_q.rem[FCS_W-1];
    assign chk_done      = ctl_q.done;
    assign chk_ok        = ctl_q.ok;
endmodule

// File: rtl/serial_fcs_unit_chk.sv
module serial_fcs_unit_chk #(
    parameter int FCS_W = 5
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fcs_out_valid,
    input logic chk_done,
    input logic chk_ok
);
    localparam int RUN_W = $clog2(FCS_W + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FCS_W + 1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!fcs_out_valid) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!fcs_out_valid && !chk_done && !chk_ok));

    // R2
    emit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(FCS_W));

    // R2
    emit_vs_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_out_valid |-> !chk_done);

    // R3
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ok |-> chk_done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && !start) |=> (chk_done && $stable(chk_ok)));

    // R5
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!chk_done && !chk_ok));
endmodule

bind serial_fcs_unit serial_fcs_unit_chk #(.FCS_W(FCS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .fcs_out_valid (fcs_out_valid),
    .chk_done      (chk_done),
    .chk_ok        (chk_ok)
);

// File: tb/serial_fcs_unit_bench.sv
module serial_fcs_unit_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         W          = 5;
    localparam logic [W:0] DIVISOR    = 6'b110101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_check = 1'b0, bit_in = 1'b0, bit_valid = 1'b0, msg_end = 1'b0;
    logic fcs_out, fcs_out_valid, chk_done, chk_ok;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit exp_q[$];
    string cur_tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_fcs_unit #(.FCS_W(W), .DIVISOR(DIVISOR)) u_serial_fcs_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_check(mode_check),
        .bit_in(bit_in), .bit_valid(bit_valid), .msg_end(msg_end),
        .fcs_out(fcs_out), .fcs_out_valid(fcs_out_valid),
        .chk_done(chk_done), .chk_ok(chk_ok)
    );

    task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference by polynomial long division of msg * X^W
    function automatic logic [W-1:0] ref_fcs(input logic [63:0] msg, input int len);
        logic [63:0] dv = msg << W;
        for (int p = len + W - 1; p >= W; p--) begin
            if (dv[p]) dv = dv ^ (64'(DIVISOR) << (p - W));
        end
        return dv[W-1:0];
    endfunction

    // monitor: pops expected serial check bits
    always @(negedge clk) begin
        if (rst_n && fcs_out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " extra fcs bit"}, 64'(fcs_out), 64'hx);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(fcs_out == e, {cur_tag, " fcs bit"}, 64'(fcs_out), 64'(e));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic open_frame(input bit chk);
        start = 1'b1; mode_check = chk; tick();
        start = 1'b0; mode_check = 1'b0;
    endtask

    task automatic send_bits(input logic [63:0] v, input int len, input bit close, input bit gaps);
        for (int i = len - 1; i >= 0; i--) begin
            bit_in = v[i]; bit_valid = 1'b1; msg_end = close && (i == 0);
            tick();
            if (gaps && i > 0) begin
                bit_valid = 1'b0; msg_end = 1'b0; bit_in = ~bit_in;
                tick();
            end
        end
        bit_valid = 1'b0; msg_end = 1'b0; bit_in = 1'b0;
    endtask

    task automatic gen_frame(input logic [63:0] msg, input int len, input logic [W-1:0] exp,
                             input bit gaps, input bit noise, input string tag);
        cur_tag = tag;
        for (int i = W - 1; i >= 0; i--) exp_q.push_back(exp[i]);
        open_frame(1'b0);
        send_bits(msg, len, 1'b1, gaps);
        for (int k = 0; k < W + 2; k++) begin
            if (noise) begin bit_valid = 1'b1; msg_end = k[0]; bit_in = ~k[0]; end // R8
            tick();
        end
        bit_valid = 1'b0; msg_end = 1'b0;
        check(exp_q.size() == 0, {tag, " burst length"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    task automatic check_frame(input logic [63:0] frm, input int len, input bit exp_ok,
                               input bit gaps, input string tag);
        open_frame(1'b1);
        send_bits(frm, len, 1'b1, gaps);
        check(chk_done == 1'b1, {tag, " done"}, 64'(chk_done), 64'd1);
        check(chk_ok == exp_ok, {tag, " ok"}, 64'(chk_ok), 64'(exp_ok));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] m2;
        logic [W-1:0] f2;
        // R1: reset state
        repeat (3) tick();
        check(!fcs_out_valid && !chk_done && !chk_ok, "R1 during reset",
              {fcs_out_valid, chk_done, chk_ok}, 0);
        rst_n = 1'b1;
        repeat (2) tick();
        check(!fcs_out_valid && !chk_done && !chk_ok, "R1 after reset",
              {fcs_out_valid, chk_done, chk_ok}, 0);

        // R8: bits before any start are ignored
        send_bits(64'b1011, 4, 1'b1, 1'b0);
        tick();
        check(!fcs_out_valid && !chk_done, "R8 idle bits", {fcs_out_valid, chk_done}, 0);

        // R2: known vector and reference agreement
        check(ref_fcs(64'b1010001101, 10) == 5'b01110, "R2 reference", ref_fcs(64'b1010001101, 10), 5'b01110);
        gen_frame(64'b1010001101, 10, 5'b01110, 1'b0, 1'b0, "R2");

        // R3: correct frame
        check_frame(64'b101000110101110, 15, 1'b1, 1'b0, "R3");

        // R5: result held, idle bits ignored (R8), start clears
        repeat (4) tick();
        check(chk_done && chk_ok, "R5 hold", {chk_done, chk_ok}, 2'b11);
        send_bits(64'b110011, 6, 1'b1, 1'b0);
        check(chk_done && chk_ok, "R8 after result", {chk_done, chk_ok}, 2'b11);
        open_frame(1'b1);
        check(!chk_done && !chk_ok, "R5 start clears", {chk_done, chk_ok}, 0);

        // R4: single-bit corruption, several positions
        check_frame(64'b101000110101110 ^ 64'h80, 15, 1'b0, 1'b0, "R4 mid");
        check_frame(64'b101000110101110 ^ 64'h1, 15, 1'b0, 1'b0, "R4 lsb");
        check_frame(64'b101000110101110 ^ 64'h4000, 15, 1'b0, 1'b0, "R4 msb");

        // R6: gaps in generate and check
        m2 = 64'b110100111011;
        f2 = ref_fcs(m2, 12);
        gen_frame(m2, 12, f2, 1'b1, 1'b0, "R6 gen");
        check_frame({m2[58:0], f2}, 12 + W, 1'b1, 1'b1, "R6 chk");

        // R7: restart mid-frame discards earlier bits
        open_frame(1'b0);
        send_bits(64'b1111, 4, 1'b0, 1'b0);
        gen_frame(64'b1010001101, 10, 5'b01110, 1'b0, 1'b0, "R7");

        // R8: noisy inputs during emission
        gen_frame(m2, 12, f2, 1'b0, 1'b1, "R8 emit");

        // R9: all-zero message
        gen_frame(64'd0, 16, 5'b00000, 1'b0, 1'b0, "R9");
        check_frame(64'd0, 16 + W, 1'b1, 1'b0, "R9 chk");

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule